// File: doc/BRIEF.md
# AXI-Lite Round-Robin Multi-Master Arbiter

This block lets several AXI-Lite masters share one downstream AXI-Lite slave. Only one master at a time is forwarded on the write path and one on the read path. Each path holds its grant until the response handshake of the current transaction completes. The slave's response is returned only to the master that issued the request.

The write path (address, data, response) and the read path (address, data) each have their own arbiter state: a grant register and a rotation pointer. A master that already presents its next request when its response handshake completes keeps the grant, so a burst of back-to-back transactions is never broken up. A master that leaves even one idle cycle gives up the grant. The next requester in rotation then gets the grant, and masters that are not requesting are skipped.

The master-facing channels are flattened vectors. Master `i` occupies bit `i` of every valid/ready vector and slice `i` of every payload vector (for example `m_awaddr[i*ADDR_W +: ADDR_W]`).

Top module: `axil_rr_arbiter`

## Requirements
- R1: While `rst` is high, no request is forwarded: `s_awvalid`, `s_wvalid` and `s_arvalid` stay low, and every master sees `m_awready`, `m_wready` and `m_arready` low, even with all master valids asserted.
- R2: Reset points both rotations at master 0. On the first edge after reset with all masters requesting, master 0 is granted, so `m_awready` and `m_arready` read `3'b001` in the following cycle. Service then proceeds in ascending index order.
- R3: A master keeps the grant when its next AWVALID (or ARVALID) is high in the cycle its response handshake completes. With three masters issuing four back-to-back transactions each, the slave sees all four of master 0, then all four of master 1, then all four of master 2. Reads behave the same way.
- R4: When every master leaves one idle cycle after each response, the grant rotates after every transaction: m0, m1, m2, m0, … on both the write path and the read path.
- R5: After a handover the search starts at the index after the last granted master and skips masters that are not requesting. With only masters 0 and 2 active, the order is m0, m2, m0, m2.
- R6: At most one master sees `m_awready`, `m_wready`, `m_arready`, `m_bvalid` or `m_rvalid` high in any cycle, and only the granted master sees any of them.
- R7: Address, write data and strobe reach the slave unchanged. The 2-bit BRESP, RDATA and the 2-bit RRESP reach the issuing master unchanged, including the code 2'b00 (OKAY).
- R8: The write and read paths arbitrate independently. A write from one master and a read from another can both be forwarded to the slave in the same cycle.
- R9: A grant is not released before the response handshake. While the granted master holds BREADY low with BVALID high, no other master's AWREADY rises and `s_awvalid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_awvalid | input | NUM_M | Write-address valid per master |
| m_awready | output | NUM_M | Write-address ready per master |
| m_awaddr | input | NUM_M*ADDR_W | Write addresses, one slice per master |
| m_wvalid | input | NUM_M | Write-data valid per master |
| m_wready | output | NUM_M | Write-data ready per master |
| m_wdata | input | NUM_M*DATA_W | Write data, one slice per master |
| m_wstrb | input | NUM_M*STRB_W | Byte strobes, one slice per master |
| m_bvalid | output | NUM_M | Write-response valid per master |
| m_bready | input | NUM_M | Write-response ready per master |
| m_bresp | output | NUM_M*2 | Write response code per master |
| m_arvalid | input | NUM_M | Read-address valid per master |
| m_arready | output | NUM_M | Read-address ready per master |
| m_araddr | input | NUM_M*ADDR_W | Read addresses, one slice per master |
| m_rvalid | output | NUM_M | Read-data valid per master |
| m_rready | input | NUM_M | Read-data ready per master |
| m_rdata | output | NUM_M*DATA_W | Read data per master |
| m_rresp | output | NUM_M*2 | Read response code per master |
| s_awvalid | output | 1 | Write-address valid to slave |
| s_awready | input | 1 | Write-address ready from slave |
| s_awaddr | output | ADDR_W | Write address to slave |
| s_wvalid | output | 1 | Write-data valid to slave |
| s_wready | input | 1 | Write-data ready from slave |
| s_wdata | output | DATA_W | Write data to slave |
| s_wstrb | output | STRB_W | Byte strobes to slave |
| s_bvalid | input | 1 | Write-response valid from slave |
| s_bready | output | 1 | Write-response ready to slave |
| s_bresp | input | 2 | Write response code from slave |
| s_arvalid | output | 1 | Read-address valid to slave |
| s_arready | input | 1 | Read-address ready from slave |
| s_araddr | output | ADDR_W | Read address to slave |
| s_rvalid | input | 1 | Read-data valid from slave |
| s_rready | output | 1 | Read-data ready to slave |
| s_rdata | input | DATA_W | Read data from slave |
| s_rresp | input | 2 | Read response code from slave |

## Verification
The critical coincidence is a response handshake that releases a grant in the same cycle as the granted master presents its next request. The arbiter must then keep the grant rather than rotate. The bench provokes this with masters that raise their next AWVALID or ARVALID as soon as the previous address is accepted. It contrasts this with masters that wait one cycle after each response, and judges both cases by the exact address order logged at the slave. A second coincidence is a write handover and a read handover in the same cycle. The bench drives it with one master writing and another reading on the same schedule, and confirms that the slave saw both valids high in one cycle.

// File: rtl/axil_arb_pkg.sv
package axil_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  localparam int RESP_W = 2;

  // index arithmetic modulo the number of masters
  function automatic int wrap_add(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/axil_arb_core.sv
module axil_arb_core
  import axil_arb_pkg::*;
#(
  parameter int NUM_M = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req,
  input  logic             done,
  output logic             busy,
  output logic [IDX_W-1:0] grant
);

  arb_state_e       state_q;
  logic [IDX_W-1:0] grant_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] pick;
  logic             found;

  // first requester at or after the rotation pointer
  always_comb begin
    found = 1'b0;
    pick  = ptr_q;
    for (int k = 0; k < NUM_M; k++) begin
      if (!found && req[IDX_W'(wrap_add(int'(ptr_q), k, NUM_M))]) begin
        found = 1'b1;
        pick  = IDX_W'(wrap_add(int'(ptr_q), k, NUM_M));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (found) begin
            state_q <= ARB_BUSY;
            grant_q <= pick;
          end
        end
        default: begin
          if (done && !req[grant_q]) begin
            state_q <= ARB_IDLE;
            ptr_q   <= IDX_W'(wrap_add(int'(grant_q), 1, NUM_M));
          end
        end
      endcase
    end
  end

  assign busy  = (state_q == ARB_BUSY);
  assign grant = grant_q;

  // R3: a master that requests again as its response completes keeps the grant
  p_hold_grant_r3: assert property (@(posedge clk) disable iff (rst)
    busy && done && req[grant] |=> busy && $stable(grant));

  // R9: no release until the response handshake
  p_keep_grant_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy && $stable(grant));

  // R4: an idle cycle at completion hands the grant back
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    busy && done && !req[grant] |=> !busy);

endmodule

// File: rtl/axil_wr_mux.sv
module axil_wr_mux #(
  parameter int NUM_M  = 3,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STRB_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy,
  input  logic [IDX_W-1:0]         grant,
  output logic                     done,
  input  logic [NUM_M-1:0]         m_awvalid,
  output logic [NUM_M-1:0]         m_awready,
  input  logic [NUM_M*ADDR_W-1:0]  m_awaddr,
  input  logic [NUM_M-1:0]         m_wvalid,
  output logic [NUM_M-1:0]         m_wready,
  input  logic [NUM_M*DATA_W-1:0]  m_wdata,
  input  logic [NUM_M*STRB_W-1:0]  m_wstrb,
  output logic [NUM_M-1:0]         m_bvalid,
  input  logic [NUM_M-1:0]         m_bready,
  output logic [NUM_M*2-1:0]       m_bresp,
  output logic                     s_awvalid,
  input  logic                     s_awready,
  output logic [ADDR_W-1:0]        s_awaddr,
  output logic                     s_wvalid,
  input  logic                     s_wready,
  output logic [DATA_W-1:0]        s_wdata,
  output logic [STRB_W-1:0]        s_wstrb,
  input  logic                     s_bvalid,
  output logic                     s_bready,
  input  logic [1:0]               s_bresp
);

  logic             aw_done_q;
  logic             w_done_q;
  logic [NUM_M-1:0] sel;

  assign s_awvalid = busy && !aw_done_q && m_awvalid[grant];
  assign s_awaddr  = m_awaddr[int'(grant)*ADDR_W +: ADDR_W];
  assign s_wvalid  = busy && !w_done_q && m_wvalid[grant];
  assign s_wdata   = m_wdata[int'(grant)*DATA_W +: DATA_W];
  assign s_wstrb   = m_wstrb[int'(grant)*STRB_W +: STRB_W];
  assign s_bready  = busy && aw_done_q && w_done_q && m_bready[grant];
  assign done      = s_bvalid && s_bready;

  for (genvar i = 0; i < NUM_M; i++) begin : g_port
    assign sel[i]         = busy && (grant == IDX_W'(i));
    assign m_awready[i]   = sel[i] && !aw_done_q && s_awready;
    assign m_wready[i]    = sel[i] && !w_done_q && s_wready;
    assign m_bvalid[i]    = sel[i] && aw_done_q && w_done_q && s_bvalid;
    assign m_bresp[i*2 +: 2] = s_bresp;
  end

  always_ff @(posedge clk) begin
    if (rst || done) begin
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
    end else begin
      if (s_awvalid && s_awready) aw_done_q <= 1'b1;
      if (s_wvalid && s_wready)   w_done_q  <= 1'b1;
    end
  end

  // R6: only one master may see a write handshake or response
  p_onehot_wr_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_awready) && $onehot0(m_wready) && $onehot0(m_bvalid));

  // R1: nothing reaches the slave without a grant
  p_idle_quiet_wr_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !s_awvalid && !s_wvalid && !s_bready);

  // R7: a completed slave response is seen by the granted master
  p_resp_route_wr_r7: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && s_bready |-> m_bvalid[grant]);

endmodule

// File: rtl/axil_rd_mux.sv
module axil_rd_mux #(
  parameter int NUM_M  = 3,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy,
  input  logic [IDX_W-1:0]         grant,
  output logic                     done,
  input  logic [NUM_M-1:0]         m_arvalid,
  output logic [NUM_M-1:0]         m_arready,
  input  logic [NUM_M*ADDR_W-1:0]  m_araddr,
  output logic [NUM_M-1:0]         m_rvalid,
  input  logic [NUM_M-1:0]         m_rready,
  output logic [NUM_M*DATA_W-1:0]  m_rdata,
  output logic [NUM_M*2-1:0]       m_rresp,
  output logic                     s_arvalid,
  input  logic                     s_arready,
  output logic [ADDR_W-1:0]        s_araddr,
  input  logic                     s_rvalid,
  output logic                     s_rready,
  input  logic [DATA_W-1:0]        s_rdata,
  input  logic [1:0]               s_rresp
);

  logic             ar_done_q;
  logic [NUM_M-1:0] sel;

  assign s_arvalid = busy && !ar_done_q && m_arvalid[grant];
  assign s_araddr  = m_araddr[int'(grant)*ADDR_W +: ADDR_W];
  assign s_rready  = busy && ar_done_q && m_rready[grant];
  assign done      = s_rvalid && s_rready;

  for (genvar i = 0; i < NUM_M; i++) begin : g_port
    assign sel[i]       = busy && (grant == IDX_W'(i));
    assign m_arready[i] = sel[i] && !ar_done_q && s_arready;
    assign m_rvalid[i]  = sel[i] && ar_done_q && s_rvalid;
    assign m_rdata[i*DATA_W +: DATA_W] = s_rdata;
    assign m_rresp[i*2 +: 2]           = s_rresp;
  end

  always_ff @(posedge clk) begin
    if (rst || done) ar_done_q <= 1'b0;
    else if (s_arvalid && s_arready) ar_done_q <= 1'b1;
  end

  // R6: only one master may see a read handshake or response
  p_onehot_rd_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_arready) && $onehot0(m_rvalid));

  // R1: nothing reaches the slave without a grant
  p_idle_quiet_rd_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !s_arvalid && !s_rready);

  // R7: a completed read response is seen by the granted master
  p_resp_route_rd_r7: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && s_rready |-> m_rvalid[grant]);

endmodule

// File: rtl/axil_rr_arbiter.sv
module axil_rr_arbiter #(
  parameter int NUM_M  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_M-1:0]         m_awvalid,
  output logic [NUM_M-1:0]         m_awready,
  input  logic [NUM_M*ADDR_W-1:0]  m_awaddr,
  input  logic [NUM_M-1:0]         m_wvalid,
  output logic [NUM_M-1:0]         m_wready,
  input  logic [NUM_M*DATA_W-1:0]  m_wdata,
  input  logic [NUM_M*STRB_W-1:0]  m_wstrb,
  output logic [NUM_M-1:0]         m_bvalid,
  input  logic [NUM_M-1:0]         m_bready,
  output logic [NUM_M*2-1:0]       m_bresp,
  input  logic [NUM_M-1:0]         m_arvalid,
  output logic [NUM_M-1:0]         m_arready,
  input  logic [NUM_M*ADDR_W-1:0]  m_araddr,
  output logic [NUM_M-1:0]         m_rvalid,
  input  logic [NUM_M-1:0]         m_rready,
  output logic [NUM_M*DATA_W-1:0]  m_rdata,
  output logic [NUM_M*2-1:0]       m_rresp,
  output logic                     s_awvalid,
  input  logic                     s_awready,
  output logic [ADDR_W-1:0]        s_awaddr,
  output logic                     s_wvalid,
  input  logic                     s_wready,
  output logic [DATA_W-1:0]        s_wdata,
  output logic [STRB_W-1:0]        s_wstrb,
  input  logic                     s_bvalid,
  output logic                     s_bready,
  input  logic [1:0]               s_bresp,
  output logic                     s_arvalid,
  input  logic                     s_arready,
  output logic [ADDR_W-1:0]        s_araddr,
  input  logic                     s_rvalid,
  output logic                     s_rready,
  input  logic [DATA_W-1:0]        s_rdata,
  input  logic [1:0]               s_rresp
);

  localparam int IDX_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;

  logic             wr_busy, rd_busy, wr_done, rd_done;
  logic [IDX_W-1:0] wr_grant, rd_grant;

  axil_arb_core #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_wr_arb (
    .clk(clk), .rst(rst), .req(m_awvalid), .done(wr_done),
    .busy(wr_busy), .grant(wr_grant)
  );

  axil_arb_core #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_rd_arb (
    .clk(clk), .rst(rst), .req(m_arvalid), .done(rd_done),
    .busy(rd_busy), .grant(rd_grant)
  );

  axil_wr_mux #(
    .NUM_M(NUM_M), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)
  ) u_wr_mux (
    .clk(clk), .rst(rst), .busy(wr_busy), .grant(wr_grant), .done(wr_done),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
  );

  axil_rd_mux #(
    .NUM_M(NUM_M), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd_mux (
    .clk(clk), .rst(rst), .busy(rd_busy), .grant(rd_grant), .done(rd_done),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
  );

  // R8: the two paths may forward at once; each still grants at most one master
  p_paths_independent_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(m_awready) <= 1 && $countones(m_arready) <= 1);

endmodule

// File: tb/axil_rr_arbiter_tb_top.sv
`timescale 1ns/1ps
module axil_rr_arbiter_tb_top;

  localparam int NM = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [NM-1:0]    m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic [NM-1:0]    m_arvalid, m_arready, m_rvalid, m_rready;
  logic [NM*AW-1:0] m_awaddr, m_araddr;
  logic [NM*DW-1:0] m_wdata, m_rdata;
  logic [NM*SW-1:0] m_wstrb;
  logic [NM*2-1:0]  m_bresp, m_rresp;
  logic             s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [AW-1:0]    s_awaddr, s_araddr;
  logic [DW-1:0]    s_wdata;
  logic [SW-1:0]    s_wstrb;
  logic             s_awready, s_wready, s_arready;
  logic             s_bvalid, s_rvalid;
  logic [1:0]       s_bresp, s_rresp;
  logic [DW-1:0]    s_rdata;

  assign s_awready = 1'b1;
  assign s_wready  = 1'b1;
  assign s_arready = 1'b1;

  axil_rr_arbiter #(.NUM_M(NM), .ADDR_W(AW), .DATA_W(DW), .STRB_W(SW)) dut_i (
    .clk(clk), .rst(rst),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
  );

  // slave model with order logs
  logic [AW-1:0] wlog_a [0:15];
  logic [DW-1:0] wlog_d [0:15];
  logic [SW-1:0] wlog_s [0:15];
  logic [AW-1:0] rlog_a [0:15];
  int wn, rn;

  always @(posedge clk) begin
    if (rst) begin
      wn <= 0; rn <= 0; s_bvalid <= 1'b0; s_rvalid <= 1'b0;
      s_bresp <= 2'b00; s_rresp <= 2'b00; s_rdata <= '0;
    end else begin
      if (s_bvalid && s_bready) s_bvalid <= 1'b0;
      if (s_rvalid && s_rready) s_rvalid <= 1'b0;
      if (s_awvalid && s_wvalid) begin
        wlog_a[wn[3:0]] <= s_awaddr;
        wlog_d[wn[3:0]] <= s_wdata;
        wlog_s[wn[3:0]] <= s_wstrb;
        wn       <= wn + 1;
        s_bvalid <= 1'b1;
        s_bresp  <= s_awaddr[1:0];
      end
      if (s_arvalid) begin
        rlog_a[rn[3:0]] <= s_araddr;
        rn       <= rn + 1;
        s_rvalid <= 1'b1;
        s_rresp  <= s_araddr[1:0];
        s_rdata  <= s_araddr * 3 + 7;
      end
    end
  end

  // concurrent monitor (R6, R8)
  int mon_err;
  bit both_seen;
  always begin
    @(negedge clk);
    #2;
    if (rst) begin
      mon_err   = 0;
      both_seen = 1'b0;
    end else begin
      if ($countones(m_awready) > 1 || $countones(m_wready) > 1 ||
          $countones(m_arready) > 1 || $countones(m_bvalid) > 1 ||
          $countones(m_rvalid) > 1)
        mon_err = mon_err + 1;
      if (s_awvalid && s_arvalid) both_seen = 1'b1;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_aw(input int m, input int k);
    logic [AW-1:0] a;
    a = AW'(100 * m + k);
    m_awaddr[m*AW +: AW] = a;
    m_wdata[m*DW +: DW]  = a ^ 32'h5A5A_0000;
    m_wstrb[m*SW +: SW]  = 4'hF ^ 4'(k);
    m_awvalid[m] = 1'b1;
    m_wvalid[m]  = 1'b1;
  endtask

  // master m issues cnt writes; gap=0 presents the next request early
  task automatic run_wr(input int m, input int cnt, input int gap);
    bit pres = 1'b0;
    bit aw_ok, w_ok, fired;
    logic [1:0] resp;
    for (int k = 0; k < cnt; k++) begin
      if (!pres) drive_aw(m, k);
      pres = 1'b0;
      aw_ok = 1'b0; w_ok = 1'b0;
      while (!(aw_ok && w_ok)) begin
        #1;
        if (m_awready[m] && m_awvalid[m]) aw_ok = 1'b1;
        if (m_wready[m] && m_wvalid[m])   w_ok  = 1'b1;
        @(negedge clk);
        if (aw_ok) m_awvalid[m] = 1'b0;
        if (w_ok)  m_wvalid[m]  = 1'b0;
      end
      if (gap == 0 && k + 1 < cnt) begin
        drive_aw(m, k + 1);
        pres = 1'b1;
      end
      fired = 1'b0;
      resp  = 2'b11;
      while (!fired) begin
        #1;
        fired = m_bvalid[m] && m_bready[m];
        if (fired) resp = m_bresp[m*2 +: 2];
        @(negedge clk);
      end
      chk(resp == 2'(k), "R7", "bresp", resp, 2'(k));
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic run_rd(input int m, input int cnt, input int gap);
    bit pres = 1'b0;
    bit fired;
    logic [DW-1:0] data;
    logic [1:0]    resp;
    logic [AW-1:0] a;
    for (int k = 0; k < cnt; k++) begin
      a = AW'(100 * m + k);
      if (!pres) begin
        m_araddr[m*AW +: AW] = a;
        m_arvalid[m] = 1'b1;
      end
      pres  = 1'b0;
      fired = 1'b0;
      while (!fired) begin
        #1;
        fired = m_arready[m] && m_arvalid[m];
        @(negedge clk);
      end
      if (gap == 0 && k + 1 < cnt) begin
        m_araddr[m*AW +: AW] = AW'(100 * m + k + 1);
        pres = 1'b1;
      end else begin
        m_arvalid[m] = 1'b0;
      end
      fired = 1'b0;
      data  = '0;
      resp  = 2'b11;
      while (!fired) begin
        #1;
        fired = m_rvalid[m] && m_rready[m];
        if (fired) begin
          data = m_rdata[m*DW +: DW];
          resp = m_rresp[m*2 +: 2];
        end
        @(negedge clk);
      end
      chk(data == a * 3 + 7, "R7", "rdata", data, a * 3 + 7);
      chk(resp == 2'(k), "R7", "rresp", resp, 2'(k));
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
    m_bready  = '1; m_rready = '1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // compare logged write/read address orders with the arithmetic expectation
  task automatic check_order(input string req, input int mode, input bit rd);
    int n, m, i;
    logic [AW-1:0] got, exp;
    n = (mode == 2) ? 8 : 12;
    chk((rd ? rn : wn) == n, req, rd ? "read count" : "write count", rd ? rn : wn, n);
    for (int p = 0; p < n; p++) begin
      case (mode)
        0: begin m = p / 4; i = p % 4; end        // back-to-back
        1: begin m = p % 3; i = p / 3; end        // rotation
        default: begin m = (p % 2) * 2; i = p / 2; end  // m1 absent
      endcase
      exp = AW'(100 * m + i);
      got = rd ? rlog_a[p] : wlog_a[p];
      chk(got == exp, req, rd ? "read order" : "write order", got, exp);
      if (!rd) begin
        chk(wlog_d[p] == (exp ^ 32'h5A5A_0000), "R7", "wdata", wlog_d[p], exp ^ 32'h5A5A_0000);
        chk(wlog_s[p] == (4'hF ^ 4'(i)), "R7", "wstrb", wlog_s[p], 4'hF ^ 4'(i));
      end
    end
  endtask

  initial begin
    m_awaddr = '0; m_wdata = '0; m_wstrb = '0; m_araddr = '0;
    m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
    m_bready = '1; m_rready = '1;
    rst = 1'b1;
    // R1: all masters requesting while reset is held
    @(negedge clk);
    m_awvalid = '1; m_wvalid = '1; m_arvalid = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(!s_awvalid && !s_wvalid && !s_arvalid, "R1", "slave valids in reset",
        {s_awvalid, s_wvalid, s_arvalid}, 0);
    chk(m_awready == '0 && m_wready == '0 && m_arready == '0, "R1", "readies in reset",
        {m_awready, m_arready}, 0);
    // R2: first edge after reset grants master 0 on both paths
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(m_awready == 3'b001, "R2", "first write grant", m_awready, 1);
    chk(m_arready == 3'b001, "R2", "first read grant", m_arready, 1);
    m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
    do_reset();

    // R3 with R2: back-to-back bursts, writes then reads
    fork
      run_wr(0, 4, 0);
      run_wr(1, 4, 0);
      run_wr(2, 4, 0);
    join
    check_order("R3", 0, 1'b0);
    fork
      run_rd(0, 4, 0);
      run_rd(1, 4, 0);
      run_rd(2, 4, 0);
    join
    check_order("R3", 0, 1'b1);

    // R4: one idle cycle after every response
    do_reset();
    fork
      run_wr(0, 4, 1);
      run_wr(1, 4, 1);
      run_wr(2, 4, 1);
    join
    check_order("R4", 1, 1'b0);
    fork
      run_rd(0, 4, 1);
      run_rd(1, 4, 1);
      run_rd(2, 4, 1);
    join
    check_order("R4", 1, 1'b1);

    // R5: master 1 silent, rotation skips it
    do_reset();
    fork
      run_wr(0, 4, 1);
      run_wr(2, 4, 1);
    join
    check_order("R5", 2, 1'b0);

    // R8: write by master 0 overlaps read by master 1
    do_reset();
    fork
      run_wr(0, 4, 1);
      run_rd(1, 4, 1);
    join
    chk(both_seen, "R8", "write and read forwarded together", both_seen, 1);
    chk(wn == 4 && rn == 4, "R8", "transfers per path", wn * 10 + rn, 44);
    chk(rlog_a[3] == 32'd103 && wlog_a[3] == 32'd3, "R8", "last addresses",
        rlog_a[3], 103);

    // R9: granted master stalls its write response
    do_reset();
    m_bready[0] = 1'b0;
    fork
      run_wr(0, 1, 0);
      run_wr(1, 1, 0);
      begin
        repeat (8) @(negedge clk);
        #1;
        chk(m_bvalid[0] && m_awready[1] == 1'b0 && !s_awvalid, "R9",
            "grant held during stalled response",
            {m_bvalid[0], m_awready[1], s_awvalid}, 3'b100);
        chk(m_bvalid[1] == 1'b0 && m_wready[1] == 1'b0, "R6",
            "waiting master sees no response or ready", {m_bvalid[1], m_wready[1]}, 0);
        @(negedge clk);
        m_bready[0] = 1'b1;
      end
    join
    chk(wn == 2 && wlog_a[0] == 32'd0 && wlog_a[1] == 32'd100, "R9",
        "order after release", wlog_a[1], 100);

    chk(mon_err == 0, "R6", "cycles with more than one master served", mon_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

endmodule